// File: doc/BRIEF.md
# Byte-Maskable Register File

This block holds four 16-bit working registers for a microcoded datapath. A write goes to a destination chosen either from two fixed bits of the instruction register (bits 7:6) or from an explicit index input. A width bit from microcode picks between a full-word write and a single-byte write. A byte write changes only the addressed byte and leaves the other byte of the destination as it was. A high-byte select sends a byte write to the upper half.

Two combinational read ports show any register by index. A fixed adder sums register A (index 0) and register B (index 1) and presents the 16-bit result and its carry at all times. An add strobe writes that sum back into register A on the clock edge. This gives the A = A + B operation. Byte writes let microcode build a 16-bit immediate from two 8-bit loads.

Top module: `bytemask_regfile`

## Requirements
- R1: While rst_ni is low, all four registers clear to 0x0000. Both read ports then return zero.
- R2: With use_idx_i = 0, the write destination is ir_i[7:6] (0 = A, 1 = B, 2, 3).
- R3: With use_idx_i = 1, the write destination is wr_idx_i, and ir_i has no effect on the destination.
- R4: wr_en_i = 1 with wide_i = 1 loads all 16 bits of wr_data_i into the destination on the rising edge.
- R5: wr_en_i = 1 with wide_i = 0 and hi_i = 0 loads wr_data_i[7:0] into bits 7:0 of the destination. Bits 15:8 keep their value.
- R6: wr_en_i = 1 with wide_i = 0 and hi_i = 1 loads wr_data_i[7:0] into bits 15:8 of the destination. Bits 7:0 keep their value.
- R7: rd0_o and rd1_o show the register named by rd0_idx_i and rd1_idx_i in the same cycle. A written value appears on them right after the write edge.
- R8: sum_o equals (A + B) mod 2^16, and carry_o is bit 16 of the unwrapped sum. Both are combinational.
- R9: add_en_i = 1 loads the current sum_o into register A on the rising edge. Register B is unchanged by the add.
- R10: If add_en_i and a write to register A fall in the same cycle, the add wins and the write is dropped. A write to any other register in that cycle still takes effect.
- R11: With wr_en_i = 0 and add_en_i = 0, no register changes, whatever the data, index, width and IR inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 8 | Instruction register; bits 7:6 name the destination |
| use_idx_i | input | 1 | 1: destination from wr_idx_i; 0: from ir_i[7:6] |
| wr_idx_i | input | 2 | Explicit destination index |
| wr_en_i | input | 1 | Write strobe |
| wide_i | input | 1 | 1: 16-bit write; 0: 8-bit write |
| hi_i | input | 1 | For 8-bit writes, 1 selects bits 15:8 |
| wr_data_i | input | 16 | Write data; byte writes take bits 7:0 |
| add_en_i | input | 1 | Load A + B into register A |
| rd0_idx_i | input | 2 | Read port 0 index |
| rd1_idx_i | input | 2 | Read port 1 index |
| rd0_o | output | 16 | Read port 0 data |
| rd1_o | output | 16 | Read port 1 data |
| sum_o | output | 16 | A + B, wrapped to 16 bits |
| carry_o | output | 1 | Carry out of A + B |

## Verification
The add write-back and the byte-masked write can land in the same cycle. When they do, both may aim at register A, or the write may aim at another register. Directed cycles assert add_en_i together with a write to A, and together with a write to B. The random phase enables both strobes at random over random destinations. After each edge, a bench model that gives the add priority on A decides every register's value. All four registers are read back through both ports and compared with that model.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned DEF_REGS     = 4;
  localparam int unsigned DEF_DATA_W   = 16;
  localparam int unsigned DEF_IR_W     = 8;
  localparam int unsigned DEF_IDX_LSB  = 6;
  localparam int unsigned ACC_IDX      = 0;  // register A
  localparam int unsigned OPND_IDX     = 1;  // register B

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_LO   = 2'd1,
    WK_HI   = 2'd2,
    WK_FULL = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/rf_adder.sv
module rf_adder #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o
);
  logic [DATA_W:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, a_i} + {1'b0, b_i};
    sum_o    = wide_sum[DATA_W-1:0];
    carry_o  = wide_sum[DATA_W];
  end
endmodule

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
  import rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_REGS,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned IR_W     = DEF_IR_W,
  parameter int unsigned IDX_LSB  = DEF_IDX_LSB,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned LANES   = DATA_W / BYTE_W
) (
  input  logic [IR_W-1:0]   ir_i,
  input  logic              use_idx_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_en_i,
  input  logic              wide_i,
  input  logic              hi_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NUM_REGS-1:0][LANES-1:0] byte_en_o,
  output logic [DATA_W-1:0] wr_word_o
);
  logic [IDX_W-1:0] dest;
  wr_kind_e         kind;
  logic [LANES-1:0] lane_mask;

  always_comb begin
    dest = use_idx_i ? wr_idx_i : ir_i[IDX_LSB +: IDX_W];
    if (!wr_en_i)    kind = WK_NONE;
    else if (wide_i) kind = WK_FULL;
    else if (hi_i)   kind = WK_HI;
    else             kind = WK_LO;

    unique case (kind)
      WK_FULL: lane_mask = '1;
      WK_HI:   lane_mask = LANES'(1) << 1;
      WK_LO:   lane_mask = LANES'(1);
      default: lane_mask = '0;
    endcase

    // byte writes replicate the low byte into every lane; masking picks one
    wr_word_o = wide_i ? wr_data_i : {LANES{wr_data_i[BYTE_W-1:0]}};
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_dec
    assign byte_en_o[r] = (dest == IDX_W'(r)) ? lane_mask : '0;
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank
  import rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_REGS,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  localparam int unsigned LANES   = DATA_W / BYTE_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_REGS-1:0][LANES-1:0] byte_en_i,
  input  logic [DATA_W-1:0]             wr_word_i,
  input  logic                          add_en_i,
  input  logic [DATA_W-1:0]             sum_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [BYTE_W-1:0] lane_q;
      logic              take_sum;

      // add write-back owns the accumulator over any port write
      assign take_sum = (r == ACC_IDX) && add_en_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              lane_q <= '0;
        else if (take_sum)        lane_q <= sum_i[l*BYTE_W +: BYTE_W];
        else if (byte_en_i[r][l]) lane_q <= wr_word_i[l*BYTE_W +: BYTE_W];
      end

      assign regs_o[r][l*BYTE_W +: BYTE_W] = lane_q;
    end
  end
endmodule

// File: rtl/bytemask_regfile.sv
module bytemask_regfile
  import rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_REGS,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned IR_W     = DEF_IR_W,
  parameter int unsigned IDX_LSB  = DEF_IDX_LSB,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned LANES   = DATA_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IR_W-1:0]   ir_i,
  input  logic              use_idx_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_en_i,
  input  logic              wide_i,
  input  logic              hi_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              add_en_i,
  input  logic [IDX_W-1:0]  rd0_idx_i,
  input  logic [IDX_W-1:0]  rd1_idx_i,
  output logic [DATA_W-1:0] rd0_o,
  output logic [DATA_W-1:0] rd1_o,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o
);
  logic [NUM_REGS-1:0][LANES-1:0] byte_en;
  logic [DATA_W-1:0]              wr_word;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  rf_wr_decode #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IR_W(IR_W), .IDX_LSB(IDX_LSB)
  ) u_dec (
    .ir_i      (ir_i),
    .use_idx_i (use_idx_i),
    .wr_idx_i  (wr_idx_i),
    .wr_en_i   (wr_en_i),
    .wide_i    (wide_i),
    .hi_i      (hi_i),
    .wr_data_i (wr_data_i),
    .byte_en_o (byte_en),
    .wr_word_o (wr_word)
  );

  rf_adder #(.DATA_W(DATA_W)) u_add (
    .a_i     (regs_q[ACC_IDX]),
    .b_i     (regs_q[OPND_IDX]),
    .sum_o   (sum_o),
    .carry_o (carry_o)
  );

  rf_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_en_i (byte_en),
    .wr_word_i (wr_word),
    .add_en_i  (add_en_i),
    .sum_i     (sum_o),
    .regs_o    (regs_q)
  );

  assign rd0_o = regs_q[rd0_idx_i];
  assign rd1_o = regs_q[rd1_idx_i];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned IR_W     = 8,
  parameter int unsigned IDX_LSB  = 6,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IR_W-1:0]   ir_i,
  input logic              use_idx_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic              wr_en_i,
  input logic              wide_i,
  input logic              hi_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              add_en_i,
  input logic [DATA_W-1:0] sum_o,
  input logic              carry_o,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);
  logic [IDX_W-1:0] tgt;
  logic             blocked;
  assign tgt     = use_idx_i ? wr_idx_i : ir_i[IDX_LSB +: IDX_W];
  assign blocked = add_en_i && (tgt == '0);

  AST_FULL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wide_i && !blocked |=> regs_q[$past(tgt)] == $past(wr_data_i)); // R4

  AST_LO_KEEPS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wide_i && !hi_i && !blocked |=>
      regs_q[$past(tgt)] == {$past(regs_q[tgt][15:8]), $past(wr_data_i[7:0])}); // R5

  AST_HI_KEEPS_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wide_i && hi_i && !blocked |=>
      regs_q[$past(tgt)] == {$past(wr_data_i[7:0]), $past(regs_q[tgt][7:0])}); // R6

  AST_SUM_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {carry_o, sum_o} == {1'b0, regs_q[0]} + {1'b0, regs_q[1]}); // R8

  AST_ADD_WRITEBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_en_i |=> regs_q[0] == $past(regs_q[0] + regs_q[1])); // R9

  AST_ADD_KEEPS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_en_i && !(wr_en_i && tgt == IDX_W'(1)) |=> $stable(regs_q[1])); // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && !add_en_i |=> $stable(regs_q)); // R11
endmodule

bind bytemask_regfile rf_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IR_W(IR_W), .IDX_LSB(IDX_LSB)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ir_i(ir_i), .use_idx_i(use_idx_i),
  .wr_idx_i(wr_idx_i), .wr_en_i(wr_en_i), .wide_i(wide_i), .hi_i(hi_i),
  .wr_data_i(wr_data_i), .add_en_i(add_en_i), .sum_o(sum_o),
  .carry_o(carry_o), .regs_q(regs_q)
);

// File: tb/sim_bytemask_regfile.sv
`timescale 1ns/100ps
module sim_bytemask_regfile;
  typedef logic [3:0][15:0] bank_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  ir_i = '0;
  logic        use_idx_i = 1'b0;
  logic [1:0]  wr_idx_i = '0;
  logic        wr_en_i = 1'b0;
  logic        wide_i = 1'b0;
  logic        hi_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        add_en_i = 1'b0;
  logic [1:0]  rd0_idx_i = '0;
  logic [1:0]  rd1_idx_i = '0;
  logic [15:0] rd0_o, rd1_o, sum_o;
  logic        carry_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bank_t mdl = '0;

  always #2.5 clk_i = ~clk_i;

  bytemask_regfile u0 (.*);

  function automatic bank_t nxt(bank_t m, bit en, bit use_i, logic [1:0] idx,
                                logic [7:0] ir, bit wide, bit hi,
                                logic [15:0] d, bit add);
    bank_t r = m;
    logic [1:0] dst = use_i ? idx : ir[7:6];
    if (en) begin
      if (wide)    r[dst] = d;
      else if (hi) r[dst][15:8] = d[7:0];
      else         r[dst][7:0]  = d[7:0];
    end
    if (add) r[0] = m[0] + m[1];
    return r;
  endfunction

  task automatic cmp(string tag, string what, logic [16:0] got, logic [16:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int r = 0; r < 4; r++) begin
      rd0_idx_i = 2'(r);
      rd1_idx_i = 2'(3 - r);
      #0.1;
      cmp(tag, $sformatf("rd0[%0d]", r), {1'b0, rd0_o}, {1'b0, mdl[r]});
      cmp(tag, $sformatf("rd1[%0d]", 3 - r), {1'b0, rd1_o}, {1'b0, mdl[3 - r]});
    end
    cmp("R8", "sum/carry", {carry_o, sum_o}, {1'b0, mdl[0]} + {1'b0, mdl[1]});
  endtask

  task automatic step(string tag, bit en, bit use_i, logic [1:0] idx,
                      logic [7:0] ir, bit wide, bit hi, logic [15:0] d, bit add);
    @(negedge clk_i);
    wr_en_i = en; use_idx_i = use_i; wr_idx_i = idx; ir_i = ir;
    wide_i = wide; hi_i = hi; wr_data_i = d; add_en_i = add;
    #0.5;
    cmp("R8", "pre-edge sum/carry", {carry_o, sum_o}, {1'b0, mdl[0]} + {1'b0, mdl[1]});
    @(posedge clk_i);
    mdl = nxt(mdl, en, use_i, idx, ir, wide, hi, d, add);
    #0.5;
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A11));
    #12.5;
    check_all("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R2: IR bits 7:6 = 2, full write (R4)
    step("R2", 1, 0, 2'd0, 8'b10_000000, 1, 0, 16'hBEEF, 0);
    step("R4", 1, 0, 2'd0, 8'b01_111111, 1, 0, 16'h1234, 0);
    // R3: index 3 while IR points at 0
    step("R3", 1, 1, 2'd3, 8'b00_000000, 1, 0, 16'hC0DE, 0);
    // R5/R6 on register 2 (0xBEEF)
    step("R5", 1, 0, 2'd0, 8'b10_000000, 0, 0, 16'hFF5A, 0);
    step("R6", 1, 1, 2'd2, 8'h00, 0, 1, 16'h0071, 0);
    step("R7", 1, 1, 2'd1, 8'h00, 0, 0, 16'h0077, 0);
    // R11: strobes off, everything else busy
    step("R11", 0, 0, 2'd1, 8'hFF, 1, 1, 16'hDEAD, 0);
    step("R11", 0, 1, 2'd2, 8'h40, 0, 0, 16'h5555, 0);
    // R8/R9: carry out and wrap
    step("R4", 1, 1, 2'd0, 8'h00, 1, 0, 16'hFFFF, 0);
    step("R4", 1, 1, 2'd1, 8'h00, 1, 0, 16'h0001, 0);
    step("R9", 0, 0, 2'd0, 8'h00, 0, 0, 16'h0000, 1);
    step("R9", 0, 0, 2'd0, 8'h00, 0, 0, 16'h0000, 1);
    // R10: add collides with write to A, then with write to B
    step("R10", 1, 1, 2'd0, 8'h00, 1, 0, 16'hAAAA, 1);
    step("R10", 1, 0, 2'd0, 8'b01_000000, 1, 0, 16'h0F0F, 1);
    step("R10", 1, 0, 2'd0, 8'b00_000000, 0, 1, 16'h0033, 1);
    // random phase
    for (int i = 0; i < 600; i++) begin
      bit en   = ($urandom % 4) != 0;
      bit add  = ($urandom % 4) == 0;
      bit wide = $urandom % 2;
      bit hi   = $urandom % 2;
      string tag;
      if (add)       tag = "R10";
      else if (!en)  tag = "R11";
      else if (wide) tag = "R4";
      else if (hi)   tag = "R6";
      else           tag = "R5";
      step(tag, en, $urandom % 2, 2'($urandom), 8'($urandom), wide, hi,
           16'($urandom), add);
    end
    // R1: asynchronous reset mid-run
    @(negedge clk_i);
    wr_en_i = 0; add_en_i = 0;
    rst_ni = 1'b0;
    mdl = '0;
    #1;
    check_all("R1");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule